// File: doc/BRIEF.md
# Bridge I/O Window Forwarding Decoder

This block makes the forward decision for I/O transactions crossing a two-port bus bridge. Software programs a 32-bit I/O window (a low and a high address, both inclusive), a command word and a bridge-control word through a write port with one select line per register. The block then judges each presented address. An address strobed on the primary side may be claimed for forwarding downstream. An address strobed on the secondary side may be claimed for forwarding upstream.

The window resets to the lowest 4KB of I/O space, and every enable resets to zero, so nothing moves until software turns it on. An optional legacy-ISA mode applies only below the 64KB boundary and only inside the window. In that mode, only the first 256 bytes of each aligned 1KB block travel downstream. The other 768 bytes of each block reverse direction and are claimed upstream. Above 64KB the window alone decides.

Each decision comes out as a one-cycle registered pulse, one clock after the strobe.

Top module: `iobr_fwd_decoder`

## Requirements
- R1: After reset, the window low register is 0x0000_0000, the high register is 0x0000_0FFF and all enables are 0. No claim is made until software writes an enable. With only the I/O enable set, addresses 0x000 to 0xFFF are claimed downstream and 0x1000 is not.
- R2: A write with `wr_base`, `wr_limit`, `wr_cmd` or `wr_ctl` high loads `wr_data` into that register at the next clock edge. A decode presented in the same cycle as the write still uses the old value. In the command word, bit 0 is the I/O enable and bit 2 is the master enable. In the bridge-control word, bit 2 is the ISA enable.
- R3: `claim_downstream` and `claim_upstream` are registered. Each is high for exactly the one cycle after its strobe (`pri_vld` or `sec_vld`).
- R4: A primary address A with low <= A <= high is claimed downstream when the I/O enable is 1. It is never claimed when the I/O enable is 0, or when A is outside the window.
- R5: When low > high, the window is empty. No primary address is claimed downstream, and a secondary address is treated as outside the window.
- R6: A secondary address outside the window is claimed upstream only when the master enable is 1. A secondary address inside the window is not claimed upstream, except in the ISA case of R8.
- R7: With ISA enable set, an in-window primary address with bits [31:16] = 0 and bits [9:8] not equal to 00 is not claimed downstream. Such an address with bits [9:8] = 00 is still claimed.
- R8: With ISA enable and master enable both set, an in-window secondary address with bits [31:16] = 0 and bits [9:8] not equal to 00 is claimed upstream.
- R9: An address with bits [31:16] not equal to 0 is decoded against the window alone, whatever the ISA enable.
- R10: For any one address, the downstream and upstream decisions are never both true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_base | input | 1 | Write select for the window low register |
| wr_limit | input | 1 | Write select for the window high register |
| wr_cmd | input | 1 | Write select for the command word |
| wr_ctl | input | 1 | Write select for the bridge-control word |
| wr_data | input | 32 | Write data |
| pri_vld | input | 1 | Primary-side I/O address strobe |
| pri_addr | input | 32 | Primary-side I/O address |
| sec_vld | input | 1 | Secondary-side I/O address strobe |
| sec_addr | input | 32 | Secondary-side I/O address |
| claim_downstream | output | 1 | Registered claim pulse for a primary address |
| claim_upstream | output | 1 | Registered claim pulse for a secondary address |

## Verification
Several properties are checked on every cycle:
- the high register reloads 0xFFF on reset, and a write lands one edge after its select;
- no claim appears without a strobe and its enable in the previous cycle;
- the two per-address decisions are exclusive;
- the ISA hole and an inverted window never produce a downstream decision.

Only the bench scenarios can show the positive outcomes. These are:
- the inclusive window edges;
- the same-cycle write still decoding with the old value;
- the upstream reversal of ISA addresses;
- ISA being ignored above 64KB;
- the single-cycle width of each pulse.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MST_BIT = 2;
  localparam int CTL_ISA_BIT = 2;

  typedef struct packed {
    logic io_en;
    logic mst_en;
    logic isa_en;
  } iobr_ctl_t;
endpackage

// File: rtl/iobr_regs.sv
module iobr_regs
  import iobr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] LIM_RST = 'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_base,
  input  logic          wr_limit,
  input  logic          wr_cmd,
  input  logic          wr_ctl,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q,
  output iobr_ctl_t     ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= LIM_RST;
      ctl_q   <= '0;
    end else begin
      if (wr_base)  base_q  <= wr_data;
      if (wr_limit) limit_q <= wr_data;
      if (wr_cmd) begin
        ctl_q.io_en  <= wr_data[CMD_IO_BIT];
        ctl_q.mst_en <= wr_data[CMD_MST_BIT];
      end
      if (wr_ctl) ctl_q.isa_en <= wr_data[CTL_ISA_BIT];
    end
  end

  AST_LIMIT_RESET: assert property (@(posedge clk) rst |=> (limit_q == LIM_RST)); // R1
  AST_BASE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> (base_q == $past(wr_data))); // R2
  AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_limit |=> (limit_q == $past(wr_data))); // R2
endmodule

// File: rtl/iobr_win_dec.sv
module iobr_win_dec #(
  parameter int AW        = 32,
  parameter int LOW_SPAN  = 16,
  parameter int BLK_SEL_H = 9,
  parameter int BLK_SEL_L = 8,
  parameter bit UPSTREAM  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          isa_en,
  output logic          fwd
);
  localparam int HI_W = AW - LOW_SPAN;

  logic in_win, low_space, isa_hole, dn_ok, up_ok;

  always_comb begin
    in_win    = (addr >= base) && (addr <= limit);
    low_space = (addr[AW-1:LOW_SPAN] == {HI_W{1'b0}});
    isa_hole  = isa_en && low_space && in_win &&
                (addr[BLK_SEL_H:BLK_SEL_L] != '0);
    dn_ok     = in_win && !isa_hole;
    up_ok     = !in_win || isa_hole;
  end

  generate
    if (UPSTREAM) begin : g_up
      assign fwd = up_ok;
    end else begin : g_dn
      assign fwd = dn_ok;
    end
  endgenerate

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(dn_ok && up_ok)); // R10
  AST_ISA_HOLE_DN: assert property (@(posedge clk) disable iff (rst)
    (isa_en && low_space && (addr[BLK_SEL_H:BLK_SEL_L] != '0)) |-> !dn_ok); // R7
  AST_EMPTY_WIN: assert property (@(posedge clk) disable iff (rst)
    (base > limit) |-> (!dn_ok && up_ok)); // R5
endmodule

// File: rtl/iobr_fwd_decoder.sv
module iobr_fwd_decoder
  import iobr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] LIM_RST = 'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_base,
  input  logic          wr_limit,
  input  logic          wr_cmd,
  input  logic          wr_ctl,
  input  logic [AW-1:0] wr_data,
  input  logic          pri_vld,
  input  logic [AW-1:0] pri_addr,
  input  logic          sec_vld,
  input  logic [AW-1:0] sec_addr,
  output logic          claim_downstream,
  output logic          claim_upstream
);
  localparam int NSIDE = 2;

  logic [AW-1:0] base_q, limit_q;
  iobr_ctl_t     ctl_q;
  logic [AW-1:0] side_addr [NSIDE];
  logic [NSIDE-1:0] side_fwd;

  assign side_addr[0] = pri_addr;
  assign side_addr[1] = sec_addr;

  iobr_regs #(.AW(AW), .LIM_RST(LIM_RST)) u_regs (
    .clk(clk), .rst(rst),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_cmd(wr_cmd), .wr_ctl(wr_ctl),
    .wr_data(wr_data),
    .base_q(base_q), .limit_q(limit_q), .ctl_q(ctl_q)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    iobr_win_dec #(.AW(AW), .UPSTREAM(g == 1)) u_dec (
      .clk(clk), .rst(rst),
      .addr(side_addr[g]), .base(base_q), .limit(limit_q),
      .isa_en(ctl_q.isa_en), .fwd(side_fwd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_downstream <= 1'b0;
      claim_upstream   <= 1'b0;
    end else begin
      claim_downstream <= pri_vld && ctl_q.io_en  && side_fwd[0];
      claim_upstream   <= sec_vld && ctl_q.mst_en && side_fwd[1];
    end
  end

  AST_DN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    claim_downstream |-> $past(pri_vld)); // R3
  AST_UP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    claim_upstream |-> $past(sec_vld)); // R3
  AST_DN_NEEDS_IOEN: assert property (@(posedge clk) disable iff (rst)
    claim_downstream |-> $past(ctl_q.io_en)); // R4
  AST_UP_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    claim_upstream |-> $past(ctl_q.mst_en)); // R6
endmodule

// File: tb/sim_iobr_fwd_decoder.sv
module sim_iobr_fwd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_base = 0, wr_limit = 0, wr_cmd = 0, wr_ctl = 0;
  logic [31:0] wr_data = '0;
  logic pri_vld = 0, sec_vld = 0;
  logic [31:0] pri_addr = '0, sec_addr = '0;
  logic claim_downstream, claim_upstream;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iobr_fwd_decoder u0 (
    .clk(clk), .rst(rst),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_cmd(wr_cmd), .wr_ctl(wr_ctl),
    .wr_data(wr_data),
    .pri_vld(pri_vld), .pri_addr(pri_addr), .sec_vld(sec_vld), .sec_addr(sec_addr),
    .claim_downstream(claim_downstream), .claim_upstream(claim_upstream)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(int which, logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_base = (which == 0); wr_limit = (which == 1);
    wr_cmd  = (which == 2); wr_ctl   = (which == 3);
    @(negedge clk);
    {wr_base, wr_limit, wr_cmd, wr_ctl} = '0;
  endtask

  task automatic dec_pri(logic [31:0] a, logic exp, string req);
    @(negedge clk); pri_vld = 1; pri_addr = a;
    @(negedge clk); pri_vld = 0;
    chk(req, claim_downstream, exp);
    chk(req, claim_upstream, 1'b0);
  endtask

  task automatic dec_sec(logic [31:0] a, logic exp, string req);
    @(negedge clk); sec_vld = 1; sec_addr = a;
    @(negedge clk); sec_vld = 0;
    chk(req, claim_upstream, exp);
    chk(req, claim_downstream, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset dn", claim_downstream, 1'b0);
    chk("R1 reset up", claim_upstream, 1'b0);
    dec_pri(32'h10, 1'b0, "R1 no enable dn");
    dec_sec(32'h2000, 1'b0, "R1 no enable up");
    wr(2, 32'h1);
    dec_pri(32'h0, 1'b1, "R1 default low");
    dec_pri(32'hFFF, 1'b1, "R1 default high");
    dec_pri(32'h1000, 1'b0, "R1 past default");
  endtask

  task automatic t_pulse;
    @(negedge clk); pri_vld = 1; pri_addr = 32'h80;
    @(negedge clk); pri_vld = 0;
    chk("R3 pulse high", claim_downstream, 1'b1);
    @(negedge clk);
    chk("R3 pulse one cycle", claim_downstream, 1'b0);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    wr_base = 1; wr_data = 32'h2000; pri_vld = 1; pri_addr = 32'h100;
    @(negedge clk);
    wr_base = 0; pri_vld = 0;
    chk("R2 same-cycle old value", claim_downstream, 1'b1);
    dec_pri(32'h100, 1'b0, "R2 new base applied");
  endtask

  task automatic t_window;
    wr(0, 32'h2000); wr(1, 32'h2FFF);
    dec_pri(32'h1FFF, 1'b0, "R4 below low");
    dec_pri(32'h2000, 1'b1, "R4 at low");
    dec_pri(32'h2FFF, 1'b1, "R4 at high");
    dec_pri(32'h3000, 1'b0, "R4 above high");
    wr(2, 32'h0);
    dec_pri(32'h2800, 1'b0, "R4 io enable off");
  endtask

  task automatic t_upstream;
    wr(2, 32'h5);
    dec_sec(32'h1FFF, 1'b1, "R6 outside up");
    dec_sec(32'h2500, 1'b0, "R6 inside no up");
    wr(2, 32'h1);
    dec_sec(32'h1FFF, 1'b0, "R6 master off");
  endtask

  task automatic t_empty;
    wr(2, 32'h5); wr(0, 32'h5000); wr(1, 32'h4000);
    dec_pri(32'h4800, 1'b0, "R5 empty dn");
    dec_sec(32'h4800, 1'b1, "R5 empty up");
  endtask

  task automatic t_isa;
    wr(0, 32'h0); wr(1, 32'hFFFF); wr(3, 32'h4);
    dec_pri(32'h0400, 1'b1, "R7 isa low 256");
    dec_pri(32'h0500, 1'b0, "R7 isa hole");
    dec_pri(32'h07FF, 1'b0, "R7 isa hole top");
    dec_pri(32'h08FF, 1'b1, "R7 isa next block");
    dec_sec(32'h0500, 1'b1, "R8 isa up");
    dec_sec(32'h0400, 1'b0, "R8 isa low not up");
    wr(2, 32'h1);
    dec_sec(32'h0500, 1'b0, "R8 isa needs master");
    wr(2, 32'h5);
  endtask

  task automatic t_high;
    wr(0, 32'h1_0000); wr(1, 32'h1_FFFF);
    dec_pri(32'h1_0500, 1'b1, "R9 high ignores isa dn");
    dec_sec(32'h1_0500, 1'b0, "R9 high ignores isa up");
    wr(0, 32'h1000); wr(1, 32'h1FFF);
    dec_sec(32'h2500, 1'b1, "R8 isa outside window up");
    dec_pri(32'h2500, 1'b0, "R7 isa outside window dn");
  endtask

  task automatic t_exclusive;
    wr(0, 32'h0); wr(1, 32'hFFFF);
    @(negedge clk);
    pri_vld = 1; sec_vld = 1; pri_addr = 32'h500; sec_addr = 32'h500;
    @(negedge clk);
    chk("R10 hole dn", claim_downstream, 1'b0);
    chk("R10 hole up", claim_upstream, 1'b1);
    pri_addr = 32'h400; sec_addr = 32'h400;
    @(negedge clk);
    pri_vld = 0; sec_vld = 0;
    chk("R10 low dn", claim_downstream, 1'b1);
    chk("R10 low up", claim_upstream, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_pulse();
    t_write_timing();
    t_window();
    t_upstream();
    t_empty();
    t_isa();
    t_high();
    t_exclusive();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule